// File: doc/BRIEF.md
# Bi-phase Reply Frame Transmitter

This block sends an 8-bit answer on a two-wire lighting-control style bus after a controller's command frame has been received. Another block reports the end of the command frame with a one-cycle mark. The local logic decides whether to answer and presents a reply byte with a one-cycle request strobe. The transmitter keeps the answer back until the minimum settling delay has passed. It then drives a Manchester-coded start bit, the eight data bits and a steady high stop period, and it raises a one-cycle done flag at the end.

A settling window opens at the end mark. If a request arrives after the latest permitted start time, the controller has already taken the silence as "no answer". The request is then dropped: a one-cycle flag reports it and the line stays idle high. Each end mark allows at most one reply.

All durations are counted in ticks. A prescaler divides the system clock by `CYC_PER_TICK`, so the half-bit time and the window limits keep their meaning at any clock rate. The defaults give one tick per microsecond at 1 MHz with a 417-tick half-bit, a 2920-tick minimum and a 9170-tick maximum.

Top module: `bphase_reply_tx`

## Requirements
- R1: After reset, and whenever no reply is held or being sent, `line_o` is high and `busy_o`, `done_o` and `dropped_o` are low.
- R2: A frame sends a start bit of value 1 and then the reply byte, most significant bit first and least significant bit last.
- R3: Every bit occupies two halves of `HALF_TICKS` ticks each. A 1 is sent as low then high, and a 0 as high then low.
- R4: After the last data bit the line stays high for four half-bit periods with no transition. At the clock edge that ends this stop period, `done_o` pulses high for one cycle and `busy_o` falls.
- R5: A request accepted while the window counter is still below `MIN_TICKS` is held, with `busy_o` high. Its frame starts on the clock edge after the counter reaches `MIN_TICKS`.
- R6: A request accepted once the counter has reached `MIN_TICKS` starts its frame on the next clock edge.
- R7: A request is accepted only while the counter sampled at the request edge is below `MAX_TICKS`. A later request makes `dropped_o` high for exactly one cycle, starting at the next edge, and leaves `line_o` high and `busy_o` low.
- R8: A request when no end mark has arrived since reset is dropped in the same way as in R7.
- R9: A request that arrives while `busy_o` is high is ignored. It produces no second frame and no drop flag.
- R10: Starting a frame uses up the window. A later request is dropped until a new end mark arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_end_i | input | 1 | One-cycle mark at the end of the received command frame |
| reply_req_i | input | 1 | One-cycle request to send `reply_byte_i` |
| reply_byte_i | input | DATA_W | Reply byte, sampled together with the request |
| line_o | output | 1 | Bus drive level, high when idle |
| busy_o | output | 1 | A reply is held or being sent |
| done_o | output | 1 | One-cycle pulse when the stop period completes |
| dropped_o | output | 1 | One-cycle pulse when a request came too late or without a window |

## Verification
Bytes with mixed patterns (A5, C3, 96), all zeros and all ones are sent and decoded half by half. Mixed patterns expose bit order and phase swaps. The solid patterns show whether each half keeps its length without help from neighbouring transitions. Requests are placed early in the window, on the exact edges at the minimum, one past the minimum, at the last accepted edge and at the first late edge, so that each start edge is compared with its expected cycle and an off-by-one in either window limit is caught. Extra requests go in during a frame, after a completed reply and before any end mark, to separate "ignored" from "dropped" from "sent".

// File: rtl/rtx_pkg.sv
// Package: shared types and frame-shape constants of the bi-phase reply transmitter.
// Assumes: one start bit and two stop bits (four steady halves) around the data.
package rtx_pkg;

    // Control state of the request handler.
    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_HOLD = 1'b1
    } ctl_state_t;

    localparam int START_BITS  = 1;
    localparam int STOP_HALVES = 4;

endpackage

// File: rtl/rtx_tick_gen.sv
// Module: divides the system clock into a one-cycle tick every CYC_PER_TICK cycles.
// Assumes: CYC_PER_TICK >= 1; with 1 the tick is high on every cycle after reset.
module rtx_tick_gen #(
    parameter int CYC_PER_TICK = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_TICK - 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == LAST);

    // Free-running prescaler that wraps on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtx_window.sv
// Module: settling window timer. An end mark arms it and clears the count; ticks
//         then advance the count, which stops at MAX_TICKS. A frame start disarms it.
// Assumes: 0 < MIN_TICKS < MAX_TICKS.
module rtx_window #(
    parameter int MIN_TICKS = 2920,
    parameter int MAX_TICKS = 9170
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mark,
    input  logic consume,
    output logic min_ok,
    output logic closed
);
    localparam int CW = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_TICKS);
    localparam logic [CW-1:0] MAX_C = CW'(MAX_TICKS);

    logic          armed;
    logic [CW-1:0] cnt;

    assign min_ok = armed && (cnt >= MIN_C);
    assign closed = !armed || (cnt >= MAX_C);

    // Arm and clear on the end mark, count ticks up to the limit, disarm on a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (mark) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else begin
            if (consume) begin
                armed <= 1'b0;
            end
            if (armed && tick && (cnt != MAX_C)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // The window only opens from an end mark.
    assert_arm_by_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(mark));

    // The window only closes early because a frame was started.
    assert_single_use_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> $past(consume));

endmodule

// File: rtl/rtx_shifter.sv
// Module: Manchester serializer. A load captures the byte behind a start bit of 1.
//         Each bit is sent as two halves of HALF_TICKS ticks (1 = low,high; 0 = high,low),
//         then four steady high halves follow. fin pulses as the last half ends.
// Assumes: HALF_TICKS >= 1; load only while not active.
module rtx_shifter #(
    parameter int DATA_W     = 8,
    parameter int HALF_TICKS = 417
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    output logic              line,
    output logic              active,
    output logic              fin
);
    import rtx_pkg::*;

    localparam int NBITS       = DATA_W + START_BITS;
    localparam int DATA_HALVES = 2 * NBITS;
    localparam int TOTAL       = DATA_HALVES + STOP_HALVES;
    localparam int HW          = $clog2(TOTAL);
    localparam int TW          = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(HALF_TICKS - 1);
    localparam logic [HW-1:0] H_LAST = HW'(TOTAL - 1);
    localparam logic [HW-1:0] H_DATA = HW'(DATA_HALVES);

    logic [NBITS-1:0] sh;
    logic [HW-1:0]    hidx;
    logic [TW-1:0]    tcnt;
    logic             cur_bit;
    logic             in_data;

    assign cur_bit = sh[NBITS-1];
    assign in_data = (hidx < H_DATA);
    assign line    = !active || !in_data || (hidx[0] ? cur_bit : ~cur_bit);

    // Step through the halves: time each one, shift after the second half of a bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            hidx   <= '0;
            tcnt   <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load && !active) begin
                sh     <= {1'b1, load_byte};
                hidx   <= '0;
                tcnt   <= '0;
                active <= 1'b1;
            end else if (active && tick) begin
                if (tcnt == T_LAST) begin
                    tcnt <= '0;
                    if (hidx == H_LAST) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        hidx <= hidx + 1'b1;
                        if (hidx[0] && in_data) begin
                            sh <= {sh[NBITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    // The end pulse lasts one cycle.
    assert_fin_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

    // The half that just ended was part of the high stop period.
    assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> $past(line));

    // A frame always opens with the low first half of the start bit.
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> !line);

endmodule

// File: rtl/bphase_reply_tx.sv
// Module: top of the bi-phase reply transmitter. Accepts a reply request while idle,
//         holds it until the settling minimum has passed, drops it if the window
//         has closed or was never opened, and hands the byte to the serializer.
// Assumes: end marks and requests are one-cycle pulses synchronous to clk.
module bphase_reply_tx #(
    parameter int DATA_W       = 8,
    parameter int CYC_PER_TICK = 1,
    parameter int HALF_TICKS   = 417,
    parameter int MIN_TICKS    = 2920,
    parameter int MAX_TICKS    = 9170
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_end_i,
    input  logic              reply_req_i,
    input  logic [DATA_W-1:0] reply_byte_i,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              dropped_o
);
    import rtx_pkg::*;

    ctl_state_t        state;
    logic [DATA_W-1:0] held;
    logic              drop_q;
    logic              tick;
    logic              min_ok;
    logic              closed;
    logic              start;
    logic              ser_active;
    logic              ser_fin;

    rtx_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtx_window #(.MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mark    (fwd_end_i),
        .consume (start),
        .min_ok  (min_ok),
        .closed  (closed)
    );

    rtx_shifter #(.DATA_W(DATA_W), .HALF_TICKS(HALF_TICKS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (start),
        .load_byte (held),
        .line      (line_o),
        .active    (ser_active),
        .fin       (ser_fin)
    );

    assign start     = (state == CTL_HOLD) && min_ok;
    assign busy_o    = (state == CTL_HOLD) || ser_active;
    assign done_o    = ser_fin;
    assign dropped_o = drop_q;

    // Request handling: accept or drop while idle, release the held byte once the minimum is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CTL_IDLE;
            held   <= '0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= 1'b0;
            case (state)
                CTL_IDLE: begin
                    if (reply_req_i && !ser_active) begin
                        if (closed) begin
                            drop_q <= 1'b1;
                        end else begin
                            state <= CTL_HOLD;
                            held  <= reply_byte_i;
                        end
                    end
                end
                CTL_HOLD: begin
                    if (min_ok) begin
                        state <= CTL_IDLE;
                    end
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end

    // Idle means a high line.
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> line_o);

    // A dropped request never leaves anything pending or on the line.
    assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dropped_o |-> (!busy_o && line_o));

    // A drop and a completed frame are never reported together.
    assert_drop_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dropped_o && done_o));

    // The serializer only starts after a held request.
    assert_start_from_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_active) |-> $past(state == CTL_HOLD));

endmodule

// File: tb/bphase_reply_tx_tb.sv
module bphase_reply_tx_tb;
    localparam int HALF = 4;
    localparam int MINT = 20;
    localparam int MAXT = 60;
    localparam int NH   = 22;

    typedef struct {
        logic [7:0]  d;
        int unsigned at;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fwd_end_i = 1'b0;
    logic       reply_req_i = 1'b0;
    logic [7:0] reply_byte_i = '0;
    logic       line_o, busy_o, done_o, dropped_o;

    int unsigned cyc = 0;
    int unsigned e0 = 0;
    int          checks = 0;
    int          fails = 0;
    bit          mon_busy = 1'b0;
    exp_t        sb[$];

    bphase_reply_tx #(
        .DATA_W(8), .CYC_PER_TICK(1), .HALF_TICKS(HALF),
        .MIN_TICKS(MINT), .MAX_TICKS(MAXT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .fwd_end_i(fwd_end_i),
        .reply_req_i(reply_req_i), .reply_byte_i(reply_byte_i),
        .line_o(line_o), .busy_o(busy_o), .done_o(done_o), .dropped_o(dropped_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NH-1:0] halves_of(input logic [7:0] d);
        logic [8:0]    bits9;
        logic [NH-1:0] v;
        bits9 = {1'b1, d};
        for (int k = 0; k < NH; k++) begin
            if (k < 18) begin
                v[NH-1-k] = (k % 2 == 0) ? ~bits9[8 - k/2] : bits9[8 - k/2];
            end else begin
                v[NH-1-k] = 1'b1;
            end
        end
        return v;
    endfunction

    task automatic mark_end();
        @(negedge clk); fwd_end_i = 1'b1;
        @(negedge clk); fwd_end_i = 1'b0;
        e0 = cyc;
    endtask

    // Drive a request so that the DUT samples it at edge 'target'.
    task automatic request(input logic [7:0] d, input int unsigned target);
        while (cyc + 1 < target) @(negedge clk);
        reply_req_i = 1'b1; reply_byte_i = d;
        @(negedge clk);
        reply_req_i = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input int unsigned at);
        exp_t it;
        it.d = d; it.at = at;
        sb.push_back(it);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy_o || mon_busy || sb.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_drop(input string req);
        int bad;
        chk(dropped_o === 1'b1, req, "dropped pulse", dropped_o, 1);
        chk(busy_o === 1'b0, req, "busy after drop", busy_o, 0);
        @(negedge clk);
        chk(dropped_o === 1'b0, req, "dropped one cycle", dropped_o, 0);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (line_o !== 1'b1 || busy_o !== 1'b0) bad++;
        end
        chk(bad == 0, req, "line idle after drop (bad cycles)", bad, 0);
    endtask

    // Monitor: decode each frame on the line and compare with the scoreboard.
    initial begin
        int unsigned   s;
        logic [NH-1:0] got;
        exp_t          it;
        forever begin
            @(negedge clk);
            if (rst_n && line_o === 1'b0) begin
                mon_busy = 1'b1;
                s = cyc;
                for (int k = 0; k < NH; k++) begin
                    repeat ((k == 0) ? HALF/2 : HALF) @(negedge clk);
                    got[NH-1-k] = line_o;
                end
                repeat (2) @(negedge clk);
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected frame", got, 0);
                end else begin
                    it = sb.pop_front();
                    chk(s == it.at, "R5/R6", "frame start edge", s, it.at);
                    chk(got[NH-1:4] == halves_of(it.d) >> 4, "R2_R3", "data halves",
                        got, halves_of(it.d));
                    chk(got[3:0] == 4'hF, "R4", "stop halves", got[3:0], 4'hF);
                    chk(done_o === 1'b1 && busy_o === 1'b0, "R4", "done at end, busy low",
                        {done_o, busy_o}, 2'b10);
                end
                @(negedge clk);
                chk(done_o === 1'b0, "R4", "done one cycle", done_o, 0);
                mon_busy = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0 && dropped_o === 1'b0,
            "R1", "reset outputs", {line_o, busy_o, done_o, dropped_o}, 4'b1000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(line_o === 1'b1 && busy_o === 1'b0, "R1", "idle after reset",
            {line_o, busy_o}, 2'b10);

        // R8: no end mark yet.
        request(8'h5A, cyc + 1);
        expect_drop("R8");

        // R5: early request held, plus R9 request while busy, then R10 reuse.
        mark_end();
        request(8'hA5, e0 + 3);
        chk(busy_o === 1'b1, "R5", "busy while held", busy_o, 1);
        push(8'hA5, e0 + MINT + 1);
        request(8'h3C, e0 + MINT + 10);
        chk(dropped_o === 1'b0, "R9", "no drop for busy request", dropped_o, 0);
        wait_idle();
        request(8'h77, cyc + 1);
        expect_drop("R10");

        // R6: request mid-window, all zeros.
        mark_end();
        request(8'h00, e0 + 35);
        push(8'h00, e0 + 36);
        wait_idle();

        // R7: last accepted edge, all ones.
        mark_end();
        request(8'hFF, e0 + MAXT);
        push(8'hFF, e0 + MAXT + 1);
        wait_idle();

        // R7: first late edge.
        mark_end();
        request(8'h81, e0 + MAXT + 1);
        expect_drop("R7");

        // R5: request on the edge the minimum is reached.
        mark_end();
        request(8'hC3, e0 + MINT);
        push(8'hC3, e0 + MINT + 1);
        wait_idle();

        // R6: request one edge past the minimum.
        mark_end();
        request(8'h96, e0 + MINT + 1);
        push(8'h96, e0 + MINT + 2);
        wait_idle();

        chk(sb.size() == 0, "R2", "all expected frames seen", sb.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule